// File: doc/BRIEF.md
# Latched Bidirectional Bus Transceiver

This block moves data between two pad groups, A and B, through two separate storage stages, one for data heading from A to B and one for data heading from B to A. Each stage has three active-low controls: a chip enable, a latch enable and an output enable. The chip enable gates both loading and driving. A stage is transparent only while its chip enable and latch enable are both low. It closes as soon as either of them goes high, and its outputs drive only while its chip enable and output enable are both low.

The data path is divided into sections of equal width, and each section carries its own six controls. A wide transfer is made by tying the controls of all sections together outside the block. Pads appear as separate input, output and drive-enable vectors. A free-running sampling clock stands in for true level-sensitive storage: a stage stores the input value present at the last clock edge at which it was open. Each input bit has a valid flag. When that flag is clear, the bit is treated as floating and the last valid level is used in its place.

Top module: `latched_bus_xcvr`

## Requirements
- R1: The default path is 36 bits wide, made of two 18-bit sections. Section s occupies bits [18s+17:18s], and each section responds only to its own bit s of every control vector.
- R2: While a direction's chip enable and latch enable are both low, its stage is transparent. The value it presents follows the effective input within the same cycle.
- R3: When the latch enable goes high while the chip enable is low, the stage keeps the input value that was present at the last clock edge at which it was open. Later input changes do not reach the outputs.
- R4: A rising chip enable during transparency also closes the stage and captures the data in the same way. When the chip enable returns low with the latch enable high, the captured value is shown.
- R5: When a direction's chip enable and output enable are both low, that direction drives every bit of its section: each drive-enable bit is 1 and the output shows the stage value.
- R6: If the chip enable or the output enable of a direction is high, its drive-enable bits are 0 and its output data bits read 0 for that section, whatever the stage holds. The stage still loads while the output enable alone is high.
- R7: The B-to-A direction works the same way with its own controls, its own stage, B inputs and A outputs. Operating one direction leaves the other direction's stored value and outputs unchanged.
- R8: For each input bit, a valid flag of 1 means the pad level is used, and the level is recorded at each clock edge. A flag of 0 means the level recorded at the last edge at which the flag was 1 is used instead.
- R9: While synchronous reset is high, every drive-enable bit is 0. After reset, both stages and all recorded bus-hold levels are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| a_i | input | 36 | Level seen on the A pads |
| a_vld_i | input | 36 | Per-bit flag: A pad is driven (1) or floating (0) |
| b_i | input | 36 | Level seen on the B pads |
| b_vld_i | input | 36 | Per-bit flag: B pad is driven (1) or floating (0) |
| ab_ce_n | input | 2 | A-to-B chip enable, one bit per section, active low |
| ab_le_n | input | 2 | A-to-B latch enable, one bit per section, active low |
| ab_oe_n | input | 2 | A-to-B output enable, one bit per section, active low |
| ba_ce_n | input | 2 | B-to-A chip enable, one bit per section, active low |
| ba_le_n | input | 2 | B-to-A latch enable, one bit per section, active low |
| ba_oe_n | input | 2 | B-to-A output enable, one bit per section, active low |
| a_o | output | 36 | Data driven onto the A pads |
| a_oe | output | 36 | Per-bit drive enable of the A pads |
| b_o | output | 36 | Data driven onto the B pads |
| b_oe | output | 36 | Per-bit drive enable of the B pads |

## Verification
The hardest case to reach from the ports is a capture caused by the chip enable rather than the latch enable. While the chip enable is high, the outputs are disabled, so the captured value cannot be seen at the moment it is taken. The bench opens a stage for one clock edge, then raises the chip enable and changes the data in the same step. It then lowers the chip enable again with the latch enable held high, so that the stored word becomes visible, and compares it with the word from before the change. Floating inputs are reached in a similar way: a level is recorded with the valid flags set, then the flags are cleared and the pads carry a different word. The flags are also cleared on only some of the bits, to check the mix of held and live levels.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int unsigned SECT_W_DEF = 18;
    localparam int unsigned N_SECT_DEF = 2;

    // Active-low controls of one direction within one section
    typedef struct packed {
        logic ce_n;
        logic le_n;
        logic oe_n;
    } dir_ctl_t;

    // State of a storage stage as decided by its controls
    typedef enum logic [1:0] {
        LM_OPEN = 2'd0,   // transparent, loading each edge
        LM_HOLD = 2'd1,   // selected, latch enable high: keep value
        LM_SHUT = 2'd2    // chip enable high: keep value, no drive
    } latch_mode_t;

    function automatic latch_mode_t latch_mode(input dir_ctl_t c);
        latch_mode_t m;
        if (c.ce_n)      m = LM_SHUT;
        else if (c.le_n) m = LM_HOLD;
        else             m = LM_OPEN;
        return m;
    endfunction

    function automatic logic drives(input dir_ctl_t c);
        return (!c.ce_n) && (!c.oe_n);
    endfunction

endpackage

// File: rtl/xcvr_bus_hold.sv
module xcvr_bus_hold #(
    parameter int unsigned W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pad_i,
    input  logic [W-1:0] vld_i,
    output logic [W-1:0] eff_o
);

    logic [W-1:0] held_r;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign eff_o[i] = vld_i[i] ? pad_i[i] : held_r[i];

        always_ff @(posedge clk) begin
            if (rst)
                held_r[i] <= 1'b0;
            else if (vld_i[i])
                held_r[i] <= pad_i[i];
        end

        AST_FLOAT_KEEP: assert property (@(posedge clk) disable iff (rst)
            !vld_i[i] |=> $stable(held_r[i])); // R8

        AST_HOLD_CLEAR: assert property (@(posedge clk)
            rst |=> (held_r[i] == 1'b0)); // R9
    end

endmodule

// File: rtl/xcvr_dir_latch.sv
module xcvr_dir_latch
    import xcvr_pkg::*;
#(
    parameter int unsigned W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  dir_ctl_t     ctl_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o,
    output logic [W-1:0] en_o
);

    latch_mode_t  mode;
    logic         open_w;
    logic         drive_w;
    logic [W-1:0] store_r;
    logic [W-1:0] view_w;

    assign mode    = latch_mode(ctl_i);
    assign open_w  = (mode == LM_OPEN);
    assign drive_w = drives(ctl_i) && !rst;
    assign view_w  = open_w ? d_i : store_r;

    always_ff @(posedge clk) begin
        if (rst)
            store_r <= '0;
        else if (open_w)
            store_r <= d_i;
    end

    assign en_o = {W{drive_w}};
    assign q_o  = drive_w ? view_w : '0;

    AST_OPEN_LOAD: assert property (@(posedge clk) disable iff (rst)
        open_w |=> (store_r == $past(d_i))); // R2

    AST_CLOSED_KEEP: assert property (@(posedge clk) disable iff (rst)
        !open_w |=> $stable(store_r)); // R3

    AST_SHOW_STORED: assert property (@(posedge clk) disable iff (rst)
        (en_o[0] && !open_w) |-> (q_o == store_r)); // R4

    AST_STAGE_CLEAR: assert property (@(posedge clk)
        rst |=> (store_r == '0)); // R9

endmodule

// File: rtl/xcvr_section.sv
module xcvr_section
    import xcvr_pkg::*;
#(
    parameter int unsigned W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  dir_ctl_t     ab_ctl_i,
    input  dir_ctl_t     ba_ctl_i,
    input  logic [W-1:0] a_eff_i,
    input  logic [W-1:0] b_eff_i,
    output logic [W-1:0] a_o,
    output logic [W-1:0] a_oe,
    output logic [W-1:0] b_o,
    output logic [W-1:0] b_oe
);

    xcvr_dir_latch #(.W(W)) u_ab (
        .clk   (clk),
        .rst   (rst),
        .ctl_i (ab_ctl_i),
        .d_i   (a_eff_i),
        .q_o   (b_o),
        .en_o  (b_oe)
    );

    xcvr_dir_latch #(.W(W)) u_ba (
        .clk   (clk),
        .rst   (rst),
        .ctl_i (ba_ctl_i),
        .d_i   (b_eff_i),
        .q_o   (a_o),
        .en_o  (a_oe)
    );

    AST_AB_GATE: assert property (@(posedge clk) disable iff (rst)
        (ab_ctl_i.ce_n || ab_ctl_i.oe_n) |-> (b_oe == '0 && b_o == '0)); // R6

    AST_BA_GATE: assert property (@(posedge clk) disable iff (rst)
        (ba_ctl_i.ce_n || ba_ctl_i.oe_n) |-> (a_oe == '0 && a_o == '0)); // R7

endmodule

// File: rtl/latched_bus_xcvr.sv
module latched_bus_xcvr
    import xcvr_pkg::*;
#(
    parameter int unsigned SECT_W = SECT_W_DEF,
    parameter int unsigned N_SECT = N_SECT_DEF,
    localparam int unsigned W     = SECT_W * N_SECT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [W-1:0]      a_i,
    input  logic [W-1:0]      a_vld_i,
    input  logic [W-1:0]      b_i,
    input  logic [W-1:0]      b_vld_i,
    input  logic [N_SECT-1:0] ab_ce_n,
    input  logic [N_SECT-1:0] ab_le_n,
    input  logic [N_SECT-1:0] ab_oe_n,
    input  logic [N_SECT-1:0] ba_ce_n,
    input  logic [N_SECT-1:0] ba_le_n,
    input  logic [N_SECT-1:0] ba_oe_n,
    output logic [W-1:0]      a_o,
    output logic [W-1:0]      a_oe,
    output logic [W-1:0]      b_o,
    output logic [W-1:0]      b_oe
);

    logic [W-1:0] a_eff;
    logic [W-1:0] b_eff;

    xcvr_bus_hold #(.W(W)) u_hold_a (
        .clk   (clk),
        .rst   (rst),
        .pad_i (a_i),
        .vld_i (a_vld_i),
        .eff_o (a_eff)
    );

    xcvr_bus_hold #(.W(W)) u_hold_b (
        .clk   (clk),
        .rst   (rst),
        .pad_i (b_i),
        .vld_i (b_vld_i),
        .eff_o (b_eff)
    );

    for (genvar s = 0; s < N_SECT; s++) begin : g_sect
        dir_ctl_t ab_ctl;
        dir_ctl_t ba_ctl;

        assign ab_ctl = '{ce_n: ab_ce_n[s], le_n: ab_le_n[s], oe_n: ab_oe_n[s]};
        assign ba_ctl = '{ce_n: ba_ce_n[s], le_n: ba_le_n[s], oe_n: ba_oe_n[s]};

        xcvr_section #(.W(SECT_W)) u_sect (
            .clk      (clk),
            .rst      (rst),
            .ab_ctl_i (ab_ctl),
            .ba_ctl_i (ba_ctl),
            .a_eff_i  (a_eff[s*SECT_W +: SECT_W]),
            .b_eff_i  (b_eff[s*SECT_W +: SECT_W]),
            .a_o      (a_o [s*SECT_W +: SECT_W]),
            .a_oe     (a_oe[s*SECT_W +: SECT_W]),
            .b_o      (b_o [s*SECT_W +: SECT_W]),
            .b_oe     (b_oe[s*SECT_W +: SECT_W])
        );

        AST_SECT_DRIVE: assert property (@(posedge clk) disable iff (rst)
            (!ab_ce_n[s] && !ab_oe_n[s]) |-> (b_oe[s*SECT_W +: SECT_W] == '1)); // R5

        AST_SECT_ALIGN: assert property (@(posedge clk) disable iff (rst)
            $countones(b_oe[s*SECT_W +: SECT_W]) == 0 ||
            $countones(b_oe[s*SECT_W +: SECT_W]) == SECT_W); // R1
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |-> (a_oe == '0 && b_oe == '0)); // R9

endmodule

// File: tb/latched_bus_xcvr_tb_top.sv
module latched_bus_xcvr_tb_top;

    localparam int W = 36;
    localparam int H = 18;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_i = '0, a_vld_i = '1, b_i = '0, b_vld_i = '1;
    logic [1:0]   ab_ce_n = 2'b11, ab_le_n = 2'b11, ab_oe_n = 2'b11;
    logic [1:0]   ba_ce_n = 2'b11, ba_le_n = 2'b11, ba_oe_n = 2'b11;
    logic [W-1:0] a_o, a_oe, b_o, b_oe;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    latched_bus_xcvr dut_i (
        .clk(clk), .rst(rst),
        .a_i(a_i), .a_vld_i(a_vld_i), .b_i(b_i), .b_vld_i(b_vld_i),
        .ab_ce_n(ab_ce_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
        .ba_ce_n(ba_ce_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n),
        .a_o(a_o), .a_oe(a_oe), .b_o(b_o), .b_oe(b_oe)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive after falling edge, sample 1 ns later
    task automatic step();
        @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic idle_all();
        step();
        ab_ce_n = 2'b11; ab_le_n = 2'b11; ab_oe_n = 2'b11;
        ba_ce_n = 2'b11; ba_le_n = 2'b11; ba_oe_n = 2'b11;
        a_vld_i = '1; b_vld_i = '1;
    endtask

    task automatic t_reset();
        ab_ce_n = 2'b00; ab_oe_n = 2'b00; ab_le_n = 2'b11;
        ba_ce_n = 2'b00; ba_oe_n = 2'b00; ba_le_n = 2'b11;
        repeat (3) step();
        settle();
        chk("R9 b_oe in reset", b_oe, '0);
        chk("R9 a_oe in reset", a_oe, '0);
        step();
        rst = 1'b0;
        settle();
        chk("R9 b_o cleared", b_o, '0);
        chk("R9 b_oe after reset", b_oe, '1);
        chk("R9 a_o cleared", a_o, '0);
        idle_all();
    endtask

    task automatic t_capture_le();
        logic [W-1:0] v1 = 36'h9_1234_5678;
        logic [W-1:0] v2 = 36'h3_0F0F_A5A5;
        step();
        a_i = v1; ab_ce_n = 2'b00; ab_le_n = 2'b00; ab_oe_n = 2'b00;
        settle();
        chk("R2 transparent v1", b_o, v1);
        chk("R5 drive enable", b_oe, '1);
        step();
        a_i = v2;
        settle();
        chk("R2 transparent v2", b_o, v2);
        step();
        ab_le_n = 2'b11; a_i = 36'hF_FFFF_0000;
        settle();
        chk("R3 held after le rise", b_o, v2);
        step();
        a_i = 36'h0_0000_FFFF;
        settle();
        chk("R3 hold ignores input", b_o, v2);
        idle_all();
    endtask

    task automatic t_capture_ce();
        logic [W-1:0] v5 = 36'hA_BCDE_F012;
        step();
        a_i = v5; ab_ce_n = 2'b00; ab_le_n = 2'b00; ab_oe_n = 2'b00;
        step();
        ab_ce_n = 2'b11; a_i = 36'h5_5555_5555;
        settle();
        chk("R6 ce high no drive", b_oe, '0);
        chk("R6 ce high data zero", b_o, '0);
        step();
        ab_le_n = 2'b11;
        step();
        ab_ce_n = 2'b00;
        settle();
        chk("R4 ce capture shown", b_o, v5);
        idle_all();
    endtask

    task automatic t_oe_gate();
        logic [W-1:0] v7 = 36'h6_C3C3_3C3C;
        step();
        a_i = v7; ab_ce_n = 2'b00; ab_le_n = 2'b00; ab_oe_n = 2'b11;
        settle();
        chk("R6 oe high no drive", b_oe, '0);
        chk("R6 oe high data zero", b_o, '0);
        step();
        ab_le_n = 2'b11; a_i = '0;
        step();
        ab_oe_n = 2'b00;
        settle();
        chk("R6 loaded while oe high", b_o, v7);
        idle_all();
    endtask

    task automatic t_sections();
        logic [W-1:0] va = 36'h1_1111_2222;
        logic [W-1:0] vb = 36'hE_EEEE_DDDD;
        step();
        a_i = va; ab_ce_n = 2'b00; ab_le_n = 2'b00; ab_oe_n = 2'b00;
        step();
        ab_le_n = 2'b10; a_i = vb;
        settle();
        chk("R1 upper held lower open", b_o, {va[W-1:H], vb[H-1:0]});
        step();
        ab_oe_n = 2'b10;
        settle();
        chk("R1 per-section enable", b_oe, {{H{1'b0}}, {H{1'b1}}});
        chk("R1 upper data off", b_o, {{H{1'b0}}, vb[H-1:0]});
        idle_all();
    endtask

    task automatic t_ba();
        logic [W-1:0] vc = 36'h7_7654_3210;
        logic [W-1:0] vd = 36'h2_AAAA_5555;
        step();
        a_i = vc; ab_ce_n = 2'b00; ab_le_n = 2'b00; ab_oe_n = 2'b00;
        step();
        ab_le_n = 2'b11;
        step();
        b_i = vd; ba_ce_n = 2'b00; ba_le_n = 2'b00; ba_oe_n = 2'b00;
        settle();
        chk("R7 a_o transparent", a_o, vd);
        chk("R7 a_oe driven", a_oe, '1);
        chk("R7 b_o unaffected", b_o, vc);
        step();
        ba_le_n = 2'b11; b_i = 36'h0_1234_0000;
        settle();
        chk("R7 a_o held", a_o, vd);
        idle_all();
    endtask

    task automatic t_bus_hold();
        logic [W-1:0] vf   = 36'hB_1357_9BDF;
        logic [W-1:0] vg   = 36'h4_2468_ACE0;
        logic [W-1:0] mask = 36'h0_0000_00FF;
        step();
        a_i = vf; a_vld_i = '1; ab_ce_n = 2'b00; ab_le_n = 2'b00; ab_oe_n = 2'b00;
        step();
        a_vld_i = '0; a_i = ~vf;
        settle();
        chk("R8 floating holds level", b_o, vf);
        step();
        a_vld_i = mask; a_i = vg;
        settle();
        chk("R8 partial valid mix", b_o, (vg & mask) | (vf & ~mask));
        idle_all();
    endtask

    initial begin
        t_reset();
        t_capture_le();
        t_capture_ce();
        t_oe_gate();
        t_sections();
        t_ba();
        t_bus_hold();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule